// File: doc/BRIEF.md
# Interrupt Request Acknowledge Sequencer

This block sits between a set of user event sources and the user-interrupt port of a PCIe DMA endpoint. Each user event input passes through a synchronizer. Its rising edge opens a request on the matching line. The block holds that request as a level toward the endpoint and watches the line's acknowledge input. When and how the request retires depends on the interrupt signalling mode in use.

There are three retire rules:

- **Legacy mode:** the request drops on the first acknowledge. The line may raise a new request only after a second acknowledge.
- **MSI mode:** the acknowledge only confirms delivery. The request stays high until host software clears it through a strobe-and-mask clear port.
- **MSI-X mode:** the first acknowledge retires the request.

If an event arrives while its line is busy, the block keeps one extra pending event for that line. That event is issued as soon as the line returns to idle. A global enable holds the whole block in a cleared state while it is low. The mode input is taken in only during that time.

Top module: `irq_ack_seq`

## Requirements
- R1: While reset is active, every bit of `req_out` is 0.
- R2: A rising edge on `event_in[i]` raises `req_out[i]` on the third clock edge after the edge, and not earlier. An input that stays high does not raise a second request.
- R3: In legacy mode (`mode` = 2'b00), an acknowledge on a requesting line drops its request on the next clock edge.
- R4: In legacy mode, after the first acknowledge the line does not raise its request again before a second acknowledge arrives, even if an event is pending. A pending event raises the request one clock after the second acknowledge.
- R5: In MSI mode (`mode` = 2'b01), an acknowledge leaves the request high. A clear strobe whose mask selects the line drops it on the next edge.
- R6: In MSI-X mode (`mode` = 2'b10), an acknowledge drops the request on the next edge and returns the line to idle. A pending event then raises the request one clock later.
- R7: When a clear and a captured event edge hit the same line in the same cycle, the clear wins. The request stays low and no event is kept.
- R8: The code `mode` = 2'b11 behaves exactly like MSI mode.
- R9: `mode` is sampled only while `enable` is low. Changing it while `enable` is high has no effect on how requests retire.
- R10: While `enable` is low, all requests, pending events and synchronizer stages are forced to 0 within one clock. Events seen during that time are lost.
- R11: A clear acts only on the lines whose `clr_mask` bit is 1. Other lines keep their requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the endpoint interrupt port |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Global enable; low clears the block and admits a new mode |
| mode | input | 2 | Retire rule: 00 legacy, 01 MSI, 10 MSI-X, 11 as MSI |
| event_in | input | NUM_LINES | Asynchronous user event inputs, rising edge significant |
| ack_in | input | NUM_LINES | Per-line acknowledge pulses from the endpoint |
| clr_stb | input | 1 | Software clear strobe |
| clr_mask | input | NUM_LINES | Lines affected by the clear strobe |
| req_out | output | NUM_LINES | Level interrupt requests toward the endpoint |

## Verification
The two functions that can collide on one line are the software clear and a freshly captured event edge. The bench provokes this by raising an event input and counting two clock edges, so that the edge detector is active. It then drives the clear strobe for exactly the next edge. The result is judged on the request output: it must stay low for several cycles afterwards, which proves that the edge was neither issued nor stored as pending. A neighbouring line that is requesting at the same time must keep its request.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   // Retire rule applied to every line
   typedef enum logic [1:0] {
      MODE_LEGACY = 2'b00,
      MODE_MSI    = 2'b01,
      MODE_MSIX   = 2'b10,
      MODE_RSVD   = 2'b11
   } irq_mode_e;

   // Per-line request lifetime
   typedef enum logic [1:0] {
      LN_IDLE      = 2'b00,
      LN_REQ       = 2'b01,
      LN_WAIT_ACK2 = 2'b10,
      LN_WAIT_CLR  = 2'b11
   } line_state_e;

   // The reserved code follows the MSI rule
   function automatic irq_mode_e fold_mode(input logic [1:0] raw);
      if (raw == 2'b11) return MODE_MSI;
      return irq_mode_e'(raw);
   endfunction

endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [WIDTH-1:0] evt_in,
   output logic [WIDTH-1:0] evt_rise
);

   localparam int LAST = STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_evt_capture: STAGES must be at least 2");
      end
   endgenerate

   // stg_q[0..STAGES-1] form the synchronizer; stg_q[LAST] is the edge history
   logic [WIDTH-1:0] stg_q [LAST+1];

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         for (int k = 0; k <= LAST; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= evt_in;
         for (int k = 1; k <= LAST; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign evt_rise = stg_q[LAST-1] & ~stg_q[LAST];

   // R10
   capture_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (evt_rise == '0));

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
   import irq_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  irq_mode_e mode,
   input  logic      evt_edge,
   input  logic      ack,
   input  logic      clr,
   output logic      req
);

   line_state_e st_q, st_d;
   logic        pend_q, pend_d, req_d;

   always_comb begin
      st_d   = st_q;
      pend_d = pend_q;
      req_d  = req;
      if (!en || clr) begin
         st_d   = LN_IDLE;
         pend_d = 1'b0;
         req_d  = 1'b0;
      end else begin
         case (st_q)
            LN_IDLE: begin
               if (evt_edge || pend_q) begin
                  st_d   = LN_REQ;
                  req_d  = 1'b1;
                  pend_d = evt_edge && pend_q;
               end
            end
            LN_REQ: begin
               if (evt_edge) pend_d = 1'b1;
               if (ack) begin
                  case (mode)
                     MODE_LEGACY: begin
                        st_d  = LN_WAIT_ACK2;
                        req_d = 1'b0;
                     end
                     MODE_MSIX: begin
                        st_d  = LN_IDLE;
                        req_d = 1'b0;
                     end
                     default: st_d = LN_WAIT_CLR;
                  endcase
               end
            end
            LN_WAIT_ACK2: begin
               if (evt_edge) pend_d = 1'b1;
               if (ack) st_d = LN_IDLE;
            end
            default: begin
               if (evt_edge) pend_d = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= LN_IDLE;
         pend_q <= 1'b0;
         req    <= 1'b0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
         req    <= req_d;
      end
   end

   // R3
   legacy_first_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && mode == MODE_LEGACY && st_q == LN_REQ && ack) |=> !req);

   // R4
   legacy_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && st_q == LN_WAIT_ACK2 && !ack) |=> !req);

   // R5
   msi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && mode == MODE_MSI && req) |=> req);

   // R6
   msix_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && mode == MODE_MSIX && st_q == LN_REQ && ack) |=> (!req && st_q == LN_IDLE));

   // R7
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!req && !pend_q));

   // R10
   disable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!req && !pend_q && st_q == LN_IDLE));

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_seq_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [1:0]           mode,
   input  logic [NUM_LINES-1:0] event_in,
   input  logic [NUM_LINES-1:0] ack_in,
   input  logic                 clr_stb,
   input  logic [NUM_LINES-1:0] clr_mask,
   output logic [NUM_LINES-1:0] req_out
);

   localparam int MAX_LINES = 16;

   generate
      if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
         $error("irq_ack_seq: NUM_LINES must lie in 1..16");
      end
   endgenerate

   // Mode register: loads only while the block is disabled
   logic [1:0] mode_q;
   irq_mode_e  mode_eff;

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= 2'b00;
      else if (!enable) mode_q <= mode;
   end

   assign mode_eff = fold_mode(mode_q);

   logic [NUM_LINES-1:0] evt_edge;
   logic [NUM_LINES-1:0] clr_hit;

   assign clr_hit = clr_mask & {NUM_LINES{clr_stb}};

   irq_evt_capture #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (enable),
      .evt_in   (event_in),
      .evt_rise (evt_edge)
   );

   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
      irq_line_fsm u_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (enable),
         .mode     (mode_eff),
         .evt_edge (evt_edge[gi]),
         .ack      (ack_in[gi]),
         .clr      (clr_hit[gi]),
         .req      (req_out[gi])
      );
   end

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> $stable(mode_q));

endmodule

// File: tb/irq_ack_seq_test.sv
module irq_ack_seq_test;

   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic [N-1:0] ev = '0;
   logic [N-1:0] ack = '0;
   logic         cstb = 1'b0;
   logic [N-1:0] cmask = '0;
   logic [N-1:0] req;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   irq_ack_seq #(.NUM_LINES(N), .SYNC_STAGES(2)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .mode     (mode),
      .event_in (ev),
      .ack_in   (ack),
      .clr_stb  (cstb),
      .clr_mask (cmask),
      .req_out  (req)
   );

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic arm(input logic [1:0] m);
      enable = 1'b0;
      mode = m;
      tick(2);
      enable = 1'b1;
      tick(1);
   endtask

   task automatic ack_pulse(input int i);
      ack[i] = 1'b1;
      tick(1);
      ack[i] = 1'b0;
   endtask

   task automatic clr_pulse(input logic [N-1:0] m);
      cstb = 1'b1;
      cmask = m;
      tick(1);
      cstb = 1'b0;
      cmask = '0;
   endtask

   task automatic fire(input int i);
      ev[i] = 1'b1;
      tick(3);
      ev[i] = 1'b0;
      tick(2);
   endtask

   task automatic t_reset;
      tick(3);
      chk("R1 outputs during reset", req, '0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 outputs after reset", req, '0);
   endtask

   task automatic t_latency;
      arm(2'b01);
      ev[7] = 1'b1;
      tick(2);
      chk("R2 no request before third edge", N'(req[7]), N'(0));
      tick(1);
      chk("R2 request on third edge", N'(req[7]), N'(1));
      clr_pulse(N'(1) << 7);
      tick(4);
      chk("R2 held level gives no second request", N'(req[7]), N'(0));
      ev[7] = 1'b0;
      tick(3);
   endtask

   task automatic t_legacy;
      arm(2'b00);
      fire(0);
      chk("R4 legacy first request", N'(req[0]), N'(1));
      fire(0);
      ack_pulse(0);
      chk("R3 legacy drop on first ack", N'(req[0]), N'(0));
      tick(4);
      chk("R4 no rearm between acks", N'(req[0]), N'(0));
      ack_pulse(0);
      chk("R4 still low on second ack edge", N'(req[0]), N'(0));
      tick(1);
      chk("R4 pending issued after second ack", N'(req[0]), N'(1));
      ack_pulse(0);
      tick(2);
      ack_pulse(0);
      tick(2);
      chk("R4 line quiet after full sequence", N'(req[0]), N'(0));
   endtask

   task automatic t_msi;
      arm(2'b01);
      fire(1);
      ack_pulse(1);
      tick(3);
      chk("R5 MSI request survives ack", N'(req[1]), N'(1));
      clr_pulse(N'(1) << 1);
      chk("R5 MSI clear drops request", N'(req[1]), N'(0));
   endtask

   task automatic t_rsvd;
      arm(2'b11);
      fire(2);
      ack_pulse(2);
      tick(3);
      chk("R8 code 11 holds like MSI", N'(req[2]), N'(1));
      clr_pulse(N'(1) << 2);
      chk("R8 code 11 cleared by software", N'(req[2]), N'(0));
   endtask

   task automatic t_msix;
      arm(2'b10);
      fire(3);
      chk("R6 MSI-X request", N'(req[3]), N'(1));
      ack_pulse(3);
      chk("R6 MSI-X drop on ack", N'(req[3]), N'(0));
      fire(3);
      fire(3);
      ack_pulse(3);
      chk("R6 MSI-X low on ack edge", N'(req[3]), N'(0));
      tick(1);
      chk("R6 MSI-X pending issued", N'(req[3]), N'(1));
      ack_pulse(3);
      chk("R6 MSI-X final drop", N'(req[3]), N'(0));
   endtask

   task automatic t_clear_race;
      arm(2'b01);
      fire(5);
      ev[4] = 1'b1;
      tick(2);
      cstb = 1'b1;
      cmask = N'(1) << 4;
      tick(1);
      cstb = 1'b0;
      cmask = '0;
      chk("R7 clear beats same-cycle edge", N'(req[4]), N'(0));
      chk("R11 unmasked line keeps request", N'(req[5]), N'(1));
      tick(4);
      chk("R7 no stored event after race", N'(req[4]), N'(0));
      ev[4] = 1'b0;
      clr_pulse(N'(1) << 5);
      chk("R11 masked line cleared", N'(req[5]), N'(0));
   endtask

   task automatic t_mode_lock;
      arm(2'b01);
      mode = 2'b10;
      tick(1);
      fire(6);
      ack_pulse(6);
      tick(2);
      chk("R9 mode change while enabled ignored", N'(req[6]), N'(1));
      clr_pulse(N'(1) << 6);
      mode = 2'b01;
   endtask

   task automatic t_disable;
      arm(2'b00);
      fire(8);
      fire(8);
      enable = 1'b0;
      tick(1);
      chk("R10 disable zeroes requests", req, '0);
      ev[9] = 1'b1;
      tick(4);
      chk("R10 events ignored while disabled", req, '0);
      ev[9] = 1'b0;
      tick(3);
      enable = 1'b1;
      tick(6);
      chk("R10 pending flushed by disable", req, '0);
   endtask

   initial begin
      #1_000_000;
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_latency();
      t_legacy();
      t_msi();
      t_rsvd();
      t_msix();
      t_clear_race();
      t_mode_lock();
      t_disable();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule